// File: doc/BRIEF.md
# Accumulator Scale-Round-Clamp Unit

This unit turns wide signed accumulator lanes into packed, saturated vector elements. Each lane is divided by a power of two. The exponent of that divisor is a per-lane signed shift amount taken from the shift operand. One of three rounding rules is applied before the division, and the quotient is then saturated to the signed or the unsigned range of the output element. A single 3-bit code selects both the rounding rule and the kind of saturation. A one-bit format input selects one of two lane layouts: eight lanes of 24 bits that produce bytes, or four lanes of 48 bits that produce halfwords.

The datapath is purely combinational from the operands to a single output register. Each result is therefore visible one clock after it is presented with `in_valid`. The accumulator storage and the register file are outside the block. The caller drives the accumulator image and the shift operand directly onto the ports.

Top module: `acc_rnd_clamp`

## Requirements
- R1: While reset is asserted, and until the first accepted operation, `out_valid`, `illegal` and `vd` are all 0.
- R2: An operation presented with `in_valid` high at a rising edge appears on `vd`/`illegal` after that edge, and `out_valid` is high for exactly that cycle. While `in_valid` is low, `vd` and `illegal` keep their values.
- R3: With `fmt_half`=0 (byte format), lane i uses `acc_in[24i+23:24i]`, shift `shamt_in[8i+7:8i]` and result `vd[8i+7:8i]`, for i in 0..7. With `fmt_half`=1 (halfword format), lane j uses `acc_in[48j+47:48j]`, shift `shamt_in[16j+15:16j]` and result `vd[16j+15:16j]`, for j in 0..3. Lanes and shift fields are two's complement.
- R4: With code bits [1:0]=00, the quotient is truncated toward zero. A negative lane gives the negation of the result for its magnitude.
- R5: With code bits [1:0]=01, the quotient is rounded to nearest, and an exact half moves away from zero.
- R6: With code bits [1:0]=10, the quotient is rounded to nearest, and an exact half goes to the even neighbour. Negative lanes are treated symmetrically.
- R7: A shift of 0 passes the lane value through unchanged to the saturation step, whatever the rounding rule.
- R8: A negative shift, or a shift of at least the lane width (24 for bytes, 48 for halfwords), forces that element to 0.
- R9: With code bit 2 clear, the result saturates unsigned. Negative results become 0, and results above the maximum become 0xFF (byte) or 0xFFFF (halfword).
- R10: With code bit 2 set, the result saturates signed, to the range 0x80..0x7F (byte) or 0x8000..0x7FFF (halfword).
- R11: Codes 3 and 7 are invalid. They set `illegal` to 1 and make `vd` all zeros. Every valid code clears `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present; updates the result register |
| fmt_half | input | 1 | 0 selects byte format, 1 selects halfword format |
| rnd_code | input | 3 | Bits [1:0] select the rounding rule, bit 2 selects signed saturation |
| acc_in | input | 192 | Accumulator lanes |
| shamt_in | input | 64 | Per-lane signed shift amounts |
| out_valid | output | 1 | Result registered in the previous cycle |
| vd | output | 64 | Packed saturated elements |
| illegal | output | 1 | The last accepted code was invalid |

## Verification
Rounding and saturation can act on the same lane in the same cycle. A rounding increment can carry a quotient that sits just inside the range over the bound, so the saturation step must still catch it. The bench provokes this with values such as 255 shifted by 1 (127.5) under signed saturation, and 511 shifted by 1 (255.5) under unsigned saturation. The expected element is the bound itself, and the bench compares each lane against a quotient-and-remainder model that rounds first and saturates afterwards. A second case mixes killed shifts, a zero shift and normal shifts in one vector, which shows that each lane's decision stays independent.

// File: rtl/acc_rnd_clamp_pkg.sv
package acc_rnd_clamp_pkg;

  // Rounding rule held in code bits [1:0]
  typedef enum logic [1:0] {
    RM_TRUNC = 2'b00,
    RM_AWAY  = 2'b01,
    RM_EVEN  = 2'b10,
    RM_BAD   = 2'b11
  } rmode_e;

  function automatic logic code_invalid(input logic [2:0] code);
    return code[1:0] == RM_BAD;
  endfunction

endpackage

// File: rtl/acc_rnd_clamp_sat.sv
// Saturates a rounded magnitude plus sign into one output element.
module acc_rnd_clamp_sat #(
  parameter int EW = 8,
  parameter int MW = 26
) (
  input  logic [MW-1:0] mag_q,
  input  logic          neg,
  input  logic          kill,
  input  logic          sclamp,
  output logic [EW-1:0] elem
);

  localparam logic [MW-1:0] UMAX = MW'((64'd1 << EW) - 64'd1);
  localparam logic [MW-1:0] NMAG = MW'(64'd1 << (EW - 1));
  localparam logic [MW-1:0] PMAX = NMAG - MW'(1);

  always_comb begin
    if (kill) begin
      elem = '0;
    end else if (!sclamp) begin
      if (neg)
        elem = '0;
      else if (mag_q > UMAX)
        elem = '1;
      else
        elem = mag_q[EW-1:0];
    end else begin
      if (!neg) begin
        if (mag_q > PMAX)
          elem = {1'b0, {(EW-1){1'b1}}};
        else
          elem = mag_q[EW-1:0];
      end else begin
        if (mag_q > NMAG)
          elem = {1'b1, {(EW-1){1'b0}}};
        else
          elem = ~mag_q[EW-1:0] + EW'(1);
      end
    end
  end

endmodule

// File: rtl/acc_rnd_clamp_lane.sv
// One lane: sign-magnitude split, rounding bias, right shift, saturation.
module acc_rnd_clamp_lane
  import acc_rnd_clamp_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic [3*EW-1:0] acc,
  input  logic [EW-1:0]   sh,
  input  rmode_e          rmode,
  input  logic            sclamp,
  output logic [EW-1:0]   elem
);

  localparam int AW = 3 * EW;
  localparam int MW = AW + 2;   // headroom: magnitude of the minimum plus bias

  logic          neg;
  logic          kill;
  logic [MW-1:0] ext;
  logic [MW-1:0] mag;
  logic [MW-1:0] trunc;
  logic [MW-1:0] half;
  logic [MW-1:0] bias;
  logic [MW-1:0] rounded;

  always_comb begin
    neg   = acc[AW-1];
    ext   = {{2{acc[AW-1]}}, acc};
    mag   = neg ? (~ext + MW'(1)) : ext;
    kill  = sh[EW-1] | (sh >= EW'(AW));
    trunc = mag >> sh;
    half  = (sh == '0) ? '0 : (MW'(1) << (sh - EW'(1)));
    unique case (rmode)
      RM_AWAY: bias = half;
      RM_EVEN: begin
        if (half == '0)
          bias = '0;
        else if (trunc[0])
          bias = half;
        else
          bias = half - MW'(1);
      end
      default: bias = '0;
    endcase
    rounded = (mag + bias) >> sh;
  end

  acc_rnd_clamp_sat #(.EW(EW), .MW(MW)) u_sat (
    .mag_q  (rounded),
    .neg    (neg),
    .kill   (kill),
    .sclamp (sclamp),
    .elem   (elem)
  );

endmodule

// File: rtl/acc_rnd_clamp.sv
// Scale, round and saturate accumulator lanes into a packed vector.
module acc_rnd_clamp
  import acc_rnd_clamp_pkg::*;
#(
  parameter int ELEM_W       = 8,
  parameter int NARROW_LANES = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic                                 fmt_half,
  input  logic [2:0]                           rnd_code,
  input  logic [NARROW_LANES*ELEM_W*3-1:0]     acc_in,
  input  logic [NARROW_LANES*ELEM_W-1:0]       shamt_in,
  output logic                                 out_valid,
  output logic [NARROW_LANES*ELEM_W-1:0]       vd,
  output logic                                 illegal
);

  localparam int NW_ACC     = 3 * ELEM_W;
  localparam int WIDE_W     = 2 * ELEM_W;
  localparam int WD_ACC     = 3 * WIDE_W;
  localparam int WIDE_LANES = NARROW_LANES / 2;
  localparam int VD_BITS    = NARROW_LANES * ELEM_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rmode_e             rmode;
  logic [VD_BITS-1:0] nar_vd;
  logic [VD_BITS-1:0] wid_vd;

  assign rmode = rmode_e'(rnd_code[1:0]);

  for (genvar i = 0; i < NARROW_LANES; i++) begin : g_nar
    acc_rnd_clamp_lane #(.EW(ELEM_W)) u_lane (
      .acc    (acc_in[i*NW_ACC +: NW_ACC]),
      .sh     (shamt_in[i*ELEM_W +: ELEM_W]),
      .rmode  (rmode),
      .sclamp (rnd_code[2]),
      .elem   (nar_vd[i*ELEM_W +: ELEM_W])
    );
  end

  for (genvar j = 0; j < WIDE_LANES; j++) begin : g_wid
    acc_rnd_clamp_lane #(.EW(WIDE_W)) u_lane (
      .acc    (acc_in[j*WD_ACC +: WD_ACC]),
      .sh     (shamt_in[j*WIDE_W +: WIDE_W]),
      .rmode  (rmode),
      .sclamp (rnd_code[2]),
      .elem   (wid_vd[j*WIDE_W +: WIDE_W])
    );
  end

  // Next-state
  logic               bad_code;
  logic [VD_BITS-1:0] vd_nxt;
  logic               ill_nxt;
  logic               vd_en;

  always_comb begin
    bad_code = code_invalid(rnd_code);
    vd_en    = in_valid;
    ill_nxt  = bad_code;
    if (bad_code)
      vd_nxt = '0;
    else if (fmt_half)
      vd_nxt = wid_vd;
    else
      vd_nxt = nar_vd;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      vd        <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (vd_en) begin
        vd      <= vd_nxt;
        illegal <= ill_nxt;
      end
    end
  end

endmodule

// File: rtl/acc_rnd_clamp_chk.sv
module acc_rnd_clamp_chk #(
  parameter int VD_BITS = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               fmt_half,
  input logic [2:0]         rnd_code,
  input logic [VD_BITS-1:0] shamt_in,
  input logic               out_valid,
  input logic [VD_BITS-1:0] vd,
  input logic               illegal
);

  // R2: output strobe tracks the accepted operation one cycle later
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: result held while nothing is accepted
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(vd) && $stable(illegal)));

  // R11: invalid code flagged, result zeroed
  p_illegal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (illegal == ($past(rnd_code[1:0]) == 2'b11)));
  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (vd == '0));

  // R8: negative byte shift kills lane 0
  p_byte_neg_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_half && rnd_code[1:0] != 2'b11 && shamt_in[7])
    |=> (vd[7:0] == 8'h00));

  // R8: oversize halfword shift kills lane 0
  p_half_big_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_half && rnd_code[1:0] != 2'b11 && !shamt_in[15]
     && shamt_in[15:0] >= 16'd48)
    |=> (vd[15:0] == 16'h0000));

endmodule

bind acc_rnd_clamp acc_rnd_clamp_chk #(.VD_BITS(VD_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .fmt_half  (fmt_half),
  .rnd_code  (rnd_code),
  .shamt_in  (shamt_in),
  .out_valid (out_valid),
  .vd        (vd),
  .illegal   (illegal)
);

// File: tb/sim_acc_rnd_clamp.sv
module sim_acc_rnd_clamp;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         fmt_half;
  logic [2:0]   rnd_code;
  logic [191:0] acc_in;
  logic [63:0]  shamt_in;
  logic         out_valid;
  logic [63:0]  vd;
  logic         illegal;

  int n_cmp = 0;
  int n_bad = 0;

  longint la [8];
  int     ls [8];

  always #5 clk = ~clk;

  acc_rnd_clamp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_half(fmt_half),
    .rnd_code(rnd_code), .acc_in(acc_in), .shamt_in(shamt_in),
    .out_valid(out_valid), .vd(vd), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model: quotient and remainder, round, then saturate
  function automatic longint ref_elem(longint x, int ew, int sh, logic [2:0] code);
    longint d, q, r, ar, sg, hi, lo;
    if (sh < 0 || sh >= 3 * ew) return 0;
    d  = longint'(1) << sh;
    q  = x / d;
    r  = x % d;
    ar = (r < 0) ? -r : r;
    sg = (x < 0) ? -1 : 1;
    if (code[1:0] == 2'b01 && ar != 0 && 2 * ar >= d) q = q + sg;
    if (code[1:0] == 2'b10 && (2 * ar > d || (2 * ar == d && (q % 2) != 0))) q = q + sg;
    if (!code[2]) begin
      hi = (longint'(1) << ew) - 1;
      if (q < 0) q = 0;
      if (q > hi) q = hi;
    end else begin
      hi = (longint'(1) << (ew - 1)) - 1;
      lo = -hi - 1;
      if (q > hi) q = hi;
      if (q < lo) q = lo;
    end
    return q & ((longint'(1) << ew) - 1);
  endfunction

  // Present la/ls with format and code, then compare after capture
  task automatic run_op(input logic half, input logic [2:0] code, input string req);
    logic [63:0] exp;
    int ew, nl;
    ew  = half ? 16 : 8;
    nl  = half ? 4 : 8;
    exp = '0;
    @(negedge clk);
    acc_in   = '0;
    shamt_in = '0;
    for (int i = 0; i < nl; i++) begin
      if (half) begin
        acc_in[48*i +: 48]   = la[i][47:0];
        shamt_in[16*i +: 16] = ls[i][15:0];
      end else begin
        acc_in[24*i +: 24]   = la[i][23:0];
        shamt_in[8*i +: 8]   = ls[i][7:0];
      end
      if (code[1:0] != 2'b11) begin
        if (half) exp[16*i +: 16] = ref_elem(la[i], ew, ls[i], code)[15:0];
        else      exp[8*i +: 8]   = ref_elem(la[i], ew, ls[i], code)[7:0];
      end
    end
    fmt_half = half;
    rnd_code = code;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, vd, exp);
    chk({req, " illegal"}, {63'd0, illegal}, {63'd0, code[1:0] == 2'b11});
    chk("R2 out_valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic set8(input longint a0, a1, a2, a3, a4, a5, a6, a7,
                      input int s0, s1, s2, s3, s4, s5, s6, s7);
    la = '{a0, a1, a2, a3, a4, a5, a6, a7};
    ls = '{s0, s1, s2, s3, s4, s5, s6, s7};
  endtask

  task automatic t_reset;
    chk("R1 reset vd", vd, 64'd0);
    chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset illegal", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_trunc;  // R4, R3
    set8(1000, -1000, 255, -7, 37, -37, 8388607, -8388608, 2, 2, 0, 1, 3, 3, 23, 23);
    run_op(1'b0, 3'd4, "R4 trunc signed");
    run_op(1'b0, 3'd0, "R4 trunc unsigned");
  endtask

  task automatic t_away;   // R5
    set8(6, -6, 10, -10, 5, 7, -5, -7, 2, 2, 2, 2, 2, 2, 2, 2);
    run_op(1'b0, 3'd5, "R5 ties away");
  endtask

  task automatic t_even;   // R6
    set8(6, -6, 10, -10, 5, 7, -5, -7, 2, 2, 2, 2, 2, 2, 2, 2);
    run_op(1'b0, 3'd6, "R6 ties even");
    set8(3, -3, 1, -1, 12, -12, 14, 9, 1, 1, 1, 1, 3, 3, 2, 1);
    run_op(1'b0, 3'd6, "R6 ties even odd/even");
  endtask

  task automatic t_zero_shift;  // R7
    set8(3, -3, 100, -100, 127, -128, 1, -1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_op(1'b0, 3'd5, "R7 zero shift away");
    run_op(1'b0, 3'd6, "R7 zero shift even");
  endtask

  task automatic t_kill;   // R8
    set8(400, -400, 8388607, -8388608, 500, 64, 9, -9, -1, 24, 23, 23, 100, -128, 0, 1);
    run_op(1'b0, 3'd4, "R8 byte kill");
    la[0] = 64'sh7FFF_FFFF_FFFF; ls[0] = 48;
    la[1] = -12345;              ls[1] = -5;
    la[2] = 64'sh7FFF_FFFF_FFFF; ls[2] = 47;
    la[3] = -1000;               ls[3] = 32767;
    run_op(1'b1, 3'd4, "R8 half kill");
  endtask

  task automatic t_unsigned;  // R9
    set8(-1, -300, 300, 255, 256, 0, 1020, -4, 0, 0, 0, 0, 0, 0, 2, 1);
    run_op(1'b0, 3'd0, "R9 unsigned clamp");
    run_op(1'b0, 3'd1, "R9 unsigned clamp away");
  endtask

  task automatic t_signed;    // R10
    set8(200, -200, -128, 127, 128, -129, 2000, -2000, 0, 0, 0, 0, 0, 0, 3, 3);
    run_op(1'b0, 3'd4, "R10 signed clamp");
  endtask

  task automatic t_carry_clamp;  // rounding pushes past the bound, R5 R10 R9
    set8(255, -257, 254, -255, 511, 509, 253, -253, 1, 1, 1, 1, 1, 1, 1, 1);
    run_op(1'b0, 3'd5, "R10 carry into signed bound");
    run_op(1'b0, 3'd1, "R9 carry into unsigned bound");
    run_op(1'b0, 3'd6, "R6 carry even");
  endtask

  task automatic t_half;    // R3 halfword layout
    la[0] = 64'sh7FFF_FFFF_FFFF;  ls[0] = 32;
    la[1] = -(longint'(1) << 47); ls[1] = 40;
    la[2] = 64'sh30000;           ls[2] = 2;
    la[3] = -98305;               ls[3] = 1;
    run_op(1'b1, 3'd5, "R3 halfword signed away");
    run_op(1'b1, 3'd2, "R3 halfword unsigned even");
    la[0] = 70000; la[1] = 65535; la[2] = 131071; la[3] = -1;
    ls = '{0, 0, 1, 0, 0, 0, 0, 0};
    run_op(1'b1, 3'd0, "R3 halfword unsigned trunc");
  endtask

  task automatic t_illegal;  // R11
    set8(1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1, 1, 1, 1, 1, 1, 1, 1);
    run_op(1'b0, 3'd3, "R11 code 3");
    run_op(1'b1, 3'd7, "R11 code 7");
    run_op(1'b0, 3'd4, "R11 valid code clears flag");
  endtask

  task automatic t_hold;    // R2
    logic [63:0] held;
    set8(90, 91, 92, 93, 94, 95, 96, 97, 1, 1, 1, 1, 1, 1, 1, 1);
    run_op(1'b0, 3'd4, "R2 before hold");
    held = vd;
    acc_in   = '1;
    shamt_in = '0;
    rnd_code = 3'd3;
    repeat (3) @(negedge clk);
    chk("R2 hold vd", vd, held);
    chk("R2 hold illegal", {63'd0, illegal}, 64'd0);
    chk("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    fmt_half = 1'b0;
    rnd_code = 3'd0;
    acc_in   = '0;
    shamt_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_trunc();
    t_away();
    t_even();
    t_zero_shift();
    t_kill();
    t_unsigned();
    t_signed();
    t_carry_clamp();
    t_half();
    t_illegal();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule